// File: doc/BRIEF.md
# I2C Serial Clock Generator with Prescaler

This block produces the serial clock for an I2C bus master from a faster input clock. A prescaler first reduces the input clock to an internal step rate. Two phase counts then set how long the clock line stays low and how long it stays released. Each phase is lengthened by a pad of 7, 6 or 5 steps. The pad depends on the prescaler setting, so the bus period can be set exactly for a given step rate.

The enable input acts as the module's run/hold control. While enable is low, the block stays idle with the line released, and it captures the prescaler and the two counts. When enable is raised, the counters start from zero, and the first phase is the released (high) phase, which matches an idle bus. Settings presented while the block runs are ignored. The line output is open-drain in meaning: 0 pulls the line low and 1 releases it. The sampled line comes back on an input, so a slave can stretch the high phase by holding the line low. Single-cycle strobes mark each release and each pull-down for the bit-level controller.

Top module: `scl_clkgen`

## Requirements
- R1: While reset is asserted, and while enable has been low for two or more cycles, `scl_o` is 1 and both strobes are 0.
- R2: With prescaler value P, the phase counter advances once every P+1 input clock cycles.
- R3: The pad d added to each phase is 7 when P is 0, 6 when P is 1, and 5 when P is 2 or more.
- R4: The high phase lasts (HI+d)*(P+1) input cycles and the low phase lasts (LO+d)*(P+1) cycles. After enable is first sampled high, `scl_o` stays 1 for one full high phase and then falls.
- R5: Prescaler and counts are captured only on clock edges where enable is sampled low. Values changed while enable is high do not alter the timing until enable has been low again.
- R6: On a step where `scl_o` is 1 and `scl_in` is sampled 0, the high-phase count does not advance, so the high phase lengthens by the stretched steps.
- R7: `rise_stb` is 1 for exactly the cycle in which `scl_o` goes from 0 to 1, and `fall_stb` for the cycle in which it goes from 1 to 0. The two are never high together.
- R8: When enable is sampled low at edge E, the block still makes its step at E. At E+1 `scl_o` returns to 1 with no strobe, and the counters restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run (1) or hold-and-load (0) |
| presc | input | PSC_W | Prescaler value P |
| low_count | input | CNT_W | Low-phase count LO |
| high_count | input | CNT_W | High-phase count HI |
| scl_in | input | 1 | Sampled level of the bus clock line |
| scl_o | output | 1 | Line drive: 0 pulls low, 1 releases |
| rise_stb | output | 1 | One-cycle strobe on release of the line |
| fall_stb | output | 1 | One-cycle strobe on pull-down of the line |

## Verification
On every cycle, the assertions check the strobe pairing and exclusivity. They also check that a sampled low line during the high phase never leads to a fall, and that the line stays released after enable has been low. The phase lengths for each pad value, the capture-only-while-held rule, the first-phase order, the exact stretch extension and the one-cycle lag on disable come from counted cycles. A behavioural per-cycle model in the bench, together with the bench's scenarios, is the only way to show them.

// File: rtl/scl_clkgen_pkg.sv
// Package: shared types and the pad rule for the serial clock generator.
// Assumes: pad depends only on whether the prescaler is 0, 1 or larger.
package scl_clkgen_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    localparam int PAD_W = 3;

    // Pad steps appended to each phase for a given prescaler class.
    function automatic logic [PAD_W-1:0] phase_pad(input logic is_zero, input logic is_one);
        if (is_zero)
            return 3'd7;
        else if (is_one)
            return 3'd6;
        return 3'd5;
    endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
// Module: captures prescaler and phase lengths while the block is held,
// and registers the run flag. Assumes lengths fit in CNT_W+1 bits.
module scl_cfg_hold
    import scl_clkgen_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int CNT_W = 16,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] presc,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    output logic             run,
    output logic [PSC_W-1:0] psc_q,
    output logic [LEN_W-1:0] len_lo,
    output logic [LEN_W-1:0] len_hi
);

    logic [PAD_W-1:0] pad;

    // Pad for the prescaler value currently presented.
    always_comb begin
        pad = phase_pad(presc == '0, presc == PSC_W'(1));
    end

    // Run flag follows enable; settings load only while enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            psc_q  <= '0;
            len_lo <= LEN_W'(7);
            len_hi <= LEN_W'(7);
        end else begin
            run <= en;
            if (!en) begin
                psc_q  <= presc;
                len_lo <= {1'b0, low_count} + LEN_W'(pad);
                len_hi <= {1'b0, high_count} + LEN_W'(pad);
            end
        end
    end

endmodule

// File: rtl/scl_prescaler.sv
// Module: divides the input clock into a step tick every div+1 cycles.
// Assumes: counter restarts from zero whenever run is low.
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);

    logic [PSC_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Wrap-around divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == div)
            cnt <= '0;
        else
            cnt <= cnt + PSC_W'(1);
    end

endmodule

// File: rtl/scl_phase_timer.sv
// Module: times the low and high phases in step ticks, freezes the high
// phase while the sampled line is low, and strobes each transition.
// Assumes: phase lengths are at least 1 step (pad guarantees 5+).
module scl_phase_timer
    import scl_clkgen_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [LEN_W-1:0] len_lo,
    input  logic [LEN_W-1:0] len_hi,
    input  logic             scl_in,
    output logic             scl_o,
    output logic             rise_stb,
    output logic             fall_stb
);

    scl_phase_e       phase;
    logic [LEN_W-1:0] pos;
    logic [LEN_W-1:0] cur_len;
    logic             last;
    logic             stretched;

    // Current phase length, end-of-phase and stretch detection.
    always_comb begin
        cur_len   = (phase == PH_HIGH) ? len_hi : len_lo;
        last      = (pos == cur_len - LEN_W'(1));
        stretched = (phase == PH_HIGH) && !scl_in;
    end

    assign scl_o = (phase == PH_HIGH);

    // Phase counter, phase toggle and edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase    <= PH_HIGH;
            pos      <= '0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
            if (tick && !stretched) begin
                if (last) begin
                    pos <= '0;
                    if (phase == PH_HIGH) begin
                        phase    <= PH_LOW;
                        fall_stb <= 1'b1;
                    end else begin
                        phase    <= PH_HIGH;
                        rise_stb <= 1'b1;
                    end
                end else begin
                    pos <= pos + LEN_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/scl_clkgen.sv
// Module: top of the serial clock generator. Loads settings while held,
// prescales the input clock and times the line phases.
// Assumes: scl_in is already synchronised to clk.
module scl_clkgen #(
    parameter int PSC_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] presc,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    input  logic             scl_in,
    output logic             scl_o,
    output logic             rise_stb,
    output logic             fall_stb
);

    localparam int LEN_W = CNT_W + 1;

    logic             run;
    logic             tick;
    logic [PSC_W-1:0] psc_q;
    logic [LEN_W-1:0] len_lo;
    logic [LEN_W-1:0] len_hi;

    scl_cfg_hold #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .presc      (presc),
        .low_count  (low_count),
        .high_count (high_count),
        .run        (run),
        .psc_q      (psc_q),
        .len_lo     (len_lo),
        .len_hi     (len_hi)
    );

    scl_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (psc_q),
        .tick  (tick)
    );

    scl_phase_timer #(.LEN_W(LEN_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .len_lo   (len_lo),
        .len_hi   (len_hi),
        .scl_in   (scl_in),
        .scl_o    (scl_o),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

endmodule

// File: rtl/scl_clkgen_checker.sv
// Module: port-level properties of the serial clock generator, bound
// into every instance of the top. Assumes synchronous active-low reset.
module scl_clkgen_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic scl_o,
    input logic rise_stb,
    input logic fall_stb
);

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb)); // R7

    AST_RISE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (scl_o && !$past(scl_o))); // R7

    AST_FALL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!scl_o && $past(scl_o))); // R7

    AST_RISE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb); // R7

    AST_RUN_RISE_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && !$past(scl_o) && $past(en, 2)) |-> rise_stb); // R7

    AST_IDLE_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en, 2) && !$past(en)) |-> (scl_o && !rise_stb && !fall_stb)); // R1

    AST_STRETCH_NOFALL: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && !scl_in) |=> !fall_stb); // R6

endmodule

bind scl_clkgen scl_clkgen_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .scl_in   (scl_in),
    .scl_o    (scl_o),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
);

// File: tb/scl_clkgen_bench.sv
module scl_clkgen_bench;

    localparam int CLK_T = 10;
    localparam int PW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [PW-1:0] presc = '0;
    logic [CW-1:0] low_count = '0;
    logic [CW-1:0] high_count = '0;
    logic          hold = 1'b0;
    logic          scl_in;
    logic          scl_o;
    logic          rise_stb;
    logic          fall_stb;

    int total = 0;
    int bad = 0;

    assign scl_in = scl_o & ~hold;

    always #(CLK_T/2) clk = ~clk;

    scl_clkgen #(.PSC_W(PW), .CNT_W(CW)) u_scl_clkgen (
        .clk(clk), .rst_n(rst_n), .en(en), .presc(presc),
        .low_count(low_count), .high_count(high_count), .scl_in(scl_in),
        .scl_o(scl_o), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    function automatic int pad_of(int p);
        if (p == 0) return 7;
        if (p == 1) return 6;
        return 5;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: remaining input cycles in the current phase.
    bit m_run = 0, m_scl = 1, m_rise = 0, m_fall = 0;
    int c_psc = 0, c_lo = 0, c_hi = 0, rem = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_scl = 1; m_rise = 0; m_fall = 0;
            c_psc = 0; c_lo = 0; c_hi = 0; rem = 0;
        end else begin
            m_rise = 0; m_fall = 0;
            if (m_run) begin
                if (!(m_scl && hold)) rem--;
                if (rem == 0) begin
                    m_scl = !m_scl;
                    if (m_scl) m_rise = 1; else m_fall = 1;
                    rem = ((m_scl ? c_hi : c_lo) + pad_of(c_psc)) * (c_psc + 1);
                end
            end else begin
                m_scl = 1;
                rem = (c_hi + pad_of(c_psc)) * (c_psc + 1);
            end
            if (!en) begin
                c_psc = int'(presc); c_lo = int'(low_count); c_hi = int'(high_count);
            end
            m_run = en;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(scl_o == m_scl, "R4 line level vs model", int'(scl_o), int'(m_scl));
            chk(rise_stb == m_rise, "R7 rise strobe vs model", int'(rise_stb), int'(m_rise));
            chk(fall_stb == m_fall, "R7 fall strobe vs model", int'(fall_stb), int'(m_fall));
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Load settings while held, enable, and time the first high phase.
    task automatic run_cfg(int p, int lo, int hi, string tag);
        int cnt;
        @(negedge clk);
        en = 1'b0; presc = PW'(p); low_count = CW'(lo); high_count = CW'(hi);
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!fall_stb && cnt < 20000);
        chk(cnt == (hi + pad_of(p)) * (p + 1) + 1, tag, cnt, (hi + pad_of(p)) * (p + 1) + 1);
    endtask

    // From a seen fall: time the low phase, then the high phase.
    task automatic measure(int exp_lo, int exp_hi, string tag);
        int cnt;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!rise_stb && cnt < 20000);
        chk(cnt == exp_lo, {tag, " low phase"}, cnt, exp_lo);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!fall_stb && cnt < 20000);
        chk(cnt == exp_hi, {tag, " high phase"}, cnt, exp_hi);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        chk(scl_o && !rise_stb && !fall_stb, "R1 reset state", int'(scl_o), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(scl_o && !rise_stb && !fall_stb, "R1 held idle", int'(scl_o), 1);

        // R3 pad 7, R4 first phase high
        run_cfg(0, 3, 2, "R4 first high P=0");
        measure(10, 9, "R3 pad 7");
        // R2 and R3 pad 6
        run_cfg(1, 4, 1, "R2 first high P=1");
        measure(20, 14, "R3 pad 6");
        // R3 boundary P=2
        run_cfg(2, 1, 1, "R3 first high P=2");
        measure(18, 18, "R3 pad 5 at P=2");
        // R2 with P=3
        run_cfg(3, 0, 2, "R2 first high P=3");
        measure(20, 28, "R2 P=3");
        // R5: change inputs while running; timing must not move
        presc = '0; low_count = CW'(9); high_count = CW'(9);
        measure(20, 28, "R5 ignored while running");
        run_cfg(0, 9, 9, "R5 new values after hold");
        measure(16, 16, "R5 new values");

        // R6 stretch by 5 steps
        run_cfg(0, 3, 2, "R6 setup");
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!rise_stb && cnt < 20000);
        hold = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk); cnt++;
            if (cnt <= 5) chk(scl_o == 1'b1, "R6 released during stretch", int'(scl_o), 1);
            if (cnt == 5) hold = 1'b0;
        end while (!fall_stb && cnt < 20000);
        chk(cnt == 14, "R6 stretched high phase", cnt, 14);

        // R8 disable in the middle of a low phase
        @(negedge clk);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(scl_o == 1'b0, "R8 step at disable edge", int'(scl_o), 0);
        @(negedge clk);
        chk(scl_o && !rise_stb && !fall_stb, "R8 released without strobe", int'(scl_o), 1);
        repeat (5) @(negedge clk);
        chk(scl_o && !rise_stb && !fall_stb, "R1 idle after disable", int'(scl_o), 1);

        summary();
        $finish;
    end

endmodule